// File: doc/BRIEF.md
# Cause/Mask Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines into one cascaded interrupt line for an upstream controller. Each line owns one bit in a cause register and one bit in a mask register. A cause bit is set whenever its request line is high and stays set until software acknowledges it. A mask bit enables its source. The pending set is cause AND mask. A registered OR of that set drives the cascade line.

Software reaches the block over a plain 32-bit register bus with address, write enable, write data and combinational read data. A cause bit is acknowledged by writing a 1 to it. The mask register is read and written as a whole word. A read-only index register returns the number of the lowest-numbered pending source and a valid flag, so a handler can find the source to service without scanning bits. A source whose request is still high after its acknowledge reappears in the cause register, which keeps level semantics intact. Writing 0 to the mask and then all ones to the cause quiets the block.

Top module: `irq_cause_mask_ctl`

## Requirements
- R1: While reset is high, and in the cycle after it drops, the cause register and the mask register are zero, the cascade output is low and the index register reads zero.
- R2: Byte address 0x0 selects the cause register, 0x4 the mask register and 0x8 the index register. Every other address reads as zero.
- R3: A request input that is high at a clock edge sets its cause bit (bit n for source n) for the next cycle, whatever the mask holds. The bit stays set after the input drops, until it is acknowledged.
- R4: A bus write to 0x0 clears each cause bit whose write-data bit is 1, unless its request is high. Cause bits whose write-data bit is 0 keep their value.
- R5: When a request is high in the same cycle that its cause bit is acknowledged, the bit stays set.
- R6: A bus write to 0x4 replaces the whole mask register with the write data from the next cycle on, and 0x4 reads back the stored mask.
- R7: The cascade output equals the OR of (cause AND mask) as it stood one clock earlier.
- R8: The index register holds the index of the lowest set bit of (cause AND mask) in bits 4:0 and a 1 in bit 31. When the pending set is empty it reads 0x00000000. All other bits are always 0.
- R9: With all requests low, writing 0 to the mask and then all ones to the cause leaves the cause at zero, the index register at zero, and the cascade output low from the following cycle on.
- R10: Writes to the index address (0x8) or to unmapped addresses change neither the cause nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_req | input | 32 | Level-sensitive request lines, bit n is source n |
| irq_out | output | 1 | Cascaded interrupt output to the upstream controller |

## Verification
On every cycle the assertions check the reset clearing, the setting of cause bits by high requests, that acknowledge clears only bits whose request is low, the mask update, the one-cycle lag of the cascade line, and that the index reported points to the lowest pending bit. The register address map and the read path, the ignoring of writes to the index and unmapped addresses, the full quiesce sequence, and the priority among several pending sources under mixed masks can only be shown by the bench's scenarios. The bench compares every visible register against a reference model, both in directed sequences and in random traffic.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;

    localparam int NSRC      = 32;
    localparam int DATA_W    = 32;
    localparam int IDX_W     = $clog2(NSRC);
    localparam int ADDR_W    = 4;
    localparam int VALID_BIT = DATA_W - 1;

    localparam logic [ADDR_W-1:0] OFS_CAUSE = ADDR_W'(4'h0);
    localparam logic [ADDR_W-1:0] OFS_MASK  = ADDR_W'(4'h4);
    localparam logic [ADDR_W-1:0] OFS_INDEX = ADDR_W'(4'h8);

    typedef enum logic [1:0] {
        SEL_CAUSE,
        SEL_MASK,
        SEL_INDEX,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic              ack_en;
        logic              mask_en;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pend_info_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_CAUSE: s = SEL_CAUSE;
            OFS_MASK:  s = SEL_MASK;
            OFS_INDEX: s = SEL_INDEX;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic pend_info_t lowest_pending(input logic [NSRC-1:0] p);
        pend_info_t r;
        r.valid = |p;
        r.idx   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (p[i]) r.idx = IDX_W'(i);
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] index_word(input pend_info_t p);
        logic [DATA_W-1:0] w;
        w            = '0;
        w[VALID_BIT] = p.valid;
        w[IDX_W-1:0] = p.idx;
        return w;
    endfunction

endpackage

// File: rtl/irqc_cause_bank.sv
`timescale 1ns/1ps
module irqc_cause_bank #(
    parameter int N = irqc_pkg::NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         ack_en,
    input  logic [N-1:0] ack_bits,
    output logic [N-1:0] cause_q
);

    generate
        for (genvar n = 0; n < N; n++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst) begin
                    cause_q[n] <= 1'b0;
                end else if (req[n]) begin
                    cause_q[n] <= 1'b1;
                end else if (ack_en && ack_bits[n]) begin
                    cause_q[n] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irqc_prio_enc.sv
`timescale 1ns/1ps
module irqc_prio_enc #(
    parameter int N = irqc_pkg::NSRC
) (
    input  logic [N-1:0]         pend,
    output irqc_pkg::pend_info_t info
);

    always_comb begin
        info = irqc_pkg::lowest_pending(pend);
    end

endmodule

// File: rtl/irqc_regif.sv
`timescale 1ns/1ps
module irqc_regif
    import irqc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [AW-1:0] addr,
    input  logic        we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] cause_q,
    input  pend_info_t  pinfo,
    output wr_req_t     wr,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] rdata
);

    reg_sel_e sel;

    always_comb begin
        sel        = decode_addr(addr);
        wr.ack_en  = we && (sel == SEL_CAUSE);
        wr.mask_en = we && (sel == SEL_MASK);
        wr.data    = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr.mask_en) begin
            mask_q <= wr.data;
        end
    end

    always_comb begin
        case (sel)
            SEL_CAUSE: rdata = cause_q;
            SEL_MASK:  rdata = mask_q;
            SEL_INDEX: rdata = index_word(pinfo);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_cause_mask_ctl.sv
`timescale 1ns/1ps
module irq_cause_mask_ctl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   irq_req,
    output logic              irq_out
);

    wr_req_t          wr;
    logic [NSRC-1:0]  cause_q;
    logic [NSRC-1:0]  mask_q;
    logic [NSRC-1:0]  pend;
    pend_info_t       pinfo;
    logic             pend_vld;
    logic [IDX_W-1:0] pend_idx;

    irqc_regif #(.AW(ADDR_W), .DW(DATA_W)) u_regif (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .cause_q (cause_q),
        .pinfo   (pinfo),
        .wr      (wr),
        .mask_q  (mask_q),
        .rdata   (bus_rdata)
    );

    irqc_cause_bank #(.N(NSRC)) u_cause (
        .clk      (clk),
        .rst      (rst),
        .req      (irq_req),
        .ack_en   (wr.ack_en),
        .ack_bits (wr.data[NSRC-1:0]),
        .cause_q  (cause_q)
    );

    assign pend = cause_q & mask_q;

    irqc_prio_enc #(.N(NSRC)) u_prio (
        .pend (pend),
        .info (pinfo)
    );

    assign pend_vld = pinfo.valid;
    assign pend_idx = pinfo.idx;

    always_ff @(posedge clk) begin
        if (rst) irq_out <= 1'b0;
        else     irq_out <= |pend;
    end

endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
module irqc_checker
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NSRC-1:0]   irq_req,
    input logic              irq_out,
    input logic [NSRC-1:0]   cause_q,
    input logic [NSRC-1:0]   mask_q,
    input logic              pend_vld,
    input logic [IDX_W-1:0]  pend_idx
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cause_q == '0 && mask_q == '0 && !irq_out));

    // R3
    req_sets_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (|irq_req) |=> ((cause_q & $past(irq_req)) == $past(irq_req)));

    // R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_CAUSE) |=>
        ((cause_q & $past(bus_wdata[NSRC-1:0]) & ~$past(irq_req)) == '0));

    // R6
    mask_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_MASK) |=> (mask_q == $past(bus_wdata[NSRC-1:0])));

    // R7
    cascade_lag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == $past(|(cause_q & mask_q))));

    // R8
    index_points_pending_chk: assert property (@(posedge clk) disable iff (rst)
        pend_vld |-> ((cause_q[pend_idx] && mask_q[pend_idx]) &&
        ((cause_q & mask_q & ((NSRC'(1) << pend_idx) - NSRC'(1))) == '0)));

    // R8
    index_valid_chk: assert property (@(posedge clk) disable iff (rst)
        pend_vld == ((cause_q & mask_q) != '0));

endmodule

bind irq_cause_mask_ctl irqc_checker u_irqc_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .irq_req   (irq_req),
    .irq_out   (irq_out),
    .cause_q   (cause_q),
    .mask_q    (mask_q),
    .pend_vld  (pend_vld),
    .pend_idx  (pend_idx)
);

// File: tb/test_irq_cause_mask_ctl.sv
`timescale 1ns/1ps
module test_irq_cause_mask_ctl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_req = '0;
    logic        irq_out;

    int nvec = 0;
    int nfail = 0;

    logic [31:0] cause_m = '0;
    logic [31:0] mask_m = '0;
    logic        out_m = 1'b0;

    always #2 clk = ~clk;

    irq_cause_mask_ctl i_irq_cause_mask_ctl (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .irq_out   (irq_out)
    );

    function automatic logic [31:0] exp_index(input logic [31:0] p);
        logic [31:0] w;
        w = 32'h0;
        for (int i = 0; i < 32; i++) begin
            if (p[i]) begin
                w = 32'h8000_0000 | 32'(i);
                break;
            end
        end
        return w;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%08h expected=%08h", what, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.3;
        d = bus_rdata;
    endtask

    task automatic check_all(input string t);
        logic [31:0] d;
        chk({31'b0, irq_out}, {31'b0, out_m}, {t, " R7 cascade output"});
        rd(4'h0, d); chk(d, cause_m, {t, " R3/R4 cause register"});
        rd(4'h4, d); chk(d, mask_m, {t, " R6 mask register"});
        rd(4'h8, d); chk(d, exp_index(cause_m & mask_m), {t, " R8 index register"});
    endtask

    // one bus cycle: drive at negedge, model at posedge, check just after
    task automatic cycle(input logic [31:0] req, input logic we, input logic [3:0] a,
                         input logic [31:0] wd, input string t);
        irq_req   = req;
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = wd;
        @(posedge clk);
        out_m = |(cause_m & mask_m);
        if (we && a == 4'h0) cause_m = cause_m & ~wd;
        cause_m = cause_m | req;
        if (we && a == 4'h4) mask_m = wd;
        #0.3;
        bus_we = 1'b0;
        check_all(t);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        irq_req = 32'h0000_0010;
        @(posedge clk);
        @(negedge clk);
        // R1: reset holds everything at zero even with a request high
        check_all("R1 in reset");
        irq_req = '0;
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 after reset");

        // R2: unmapped address reads zero
        rd(4'hC, d); chk(d, 32'h0, "R2 unmapped read");
        rd(4'h2, d); chk(d, 32'h0, "R2 unmapped read");
        @(negedge clk);

        // R3: cause latches regardless of mask and holds after drop
        cycle(32'h0000_0020, 1'b0, 4'h0, '0, "R3 set unmasked");
        cycle(32'h0, 1'b0, 4'h0, '0, "R3 hold");
        // R6: mask write and readback
        cycle(32'h0, 1'b1, 4'h4, 32'hFFFF_0220, "R6 mask write");
        cycle(32'h0, 1'b0, 4'h0, '0, "R7 output rises");
        // R8: lowest of several pending
        cycle(32'h0002_0200, 1'b0, 4'h0, '0, "R8 multiple");
        cycle(32'h0, 1'b0, 4'h0, '0, "R8 lowest five");
        // R4: ack bit 5 only, others stay
        cycle(32'h0, 1'b1, 4'h0, 32'h0000_0020, "R4 ack one");
        cycle(32'h0, 1'b0, 4'h0, '0, "R8 next lowest");
        // R5: ack while request held, set wins
        cycle(32'h0000_0200, 1'b1, 4'h0, 32'h0000_0200, "R5 set wins");
        cycle(32'h0, 1'b0, 4'h0, '0, "R5 still set");
        // R10: writes to index and unmapped addresses ignored
        cycle(32'h0, 1'b1, 4'h8, 32'hFFFF_FFFF, "R10 index write");
        cycle(32'h0, 1'b1, 4'hC, 32'h0000_0000, "R10 unmapped write");
        // R9: quiesce
        cycle(32'h0, 1'b1, 4'h4, 32'h0, "R9 mask off");
        cycle(32'h0, 1'b1, 4'h0, 32'hFFFF_FFFF, "R9 ack all");
        cycle(32'h0, 1'b0, 4'h0, '0, "R9 idle");
        chk(cause_m, 32'h0, "R9 model cause");
        chk({31'b0, irq_out}, 32'h0, "R9 output low");
        // level re-assert after ack (R5/R3)
        cycle(32'h8000_0001, 1'b1, 4'h4, 32'h8000_0001, "R3 edge bits");
        cycle(32'h8000_0001, 1'b1, 4'h0, 32'hFFFF_FFFF, "R5 reassert");
        cycle(32'h0, 1'b1, 4'h0, 32'h0000_0001, "R4 partial ack");
        cycle(32'h0, 1'b0, 4'h0, '0, "R8 index 31");

        // random traffic
        for (int k = 0; k < 500; k++) begin
            logic [31:0] rq;
            logic [3:0]  a;
            logic        w;
            logic [31:0] wd;
            rq = $urandom() & $urandom() & $urandom();
            w  = ($urandom() % 3) != 0;
            case ($urandom() % 4)
                0: a = 4'h0;
                1: a = 4'h4;
                2: a = 4'h8;
                default: a = 4'(($urandom() % 16));
            endcase
            wd = $urandom();
            cycle(rq, w, a, wd, "random R3 R4 R6 R7 R8 R10");
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule